// File: doc/BRIEF.md
# Serial Configuration and Status Register Slave

This block is a small register slave for a three-channel line-conditioning device. An external controller reaches it through a four-wire serial port with an active-low select, a serial clock, a data input and a data output. Every frame starts with a read/write flag, followed by a register address and one data byte. Each channel has one read/write control register of six configuration bits and one read-only status register. The status register reports that channel's FIFO-limit flag, which arrives as a plain input.

A mode input selects between host control and pin control. Under host control the serial port reads and writes the registers. Under pin control the serial port is ignored, and the per-channel jitter-attenuator enable bit that leaves the block comes from a dedicated input pin instead of the register. The serial lines are brought into the block's clock domain through two-flop synchronisers. Edges of the serial clock are then detected in that domain, so the serial clock must run several times slower than the block clock.

Top module: `serial_cfg_regs`

## Requirements
- R1: Rising serial-clock edges are counted from chip-select assertion, starting at 0. Edge 0 carries the operation flag (1 = read, 0 = write). Edges 1 to 5 carry a 5-bit address, least significant bit first. Edge 6 carries a must-be-zero bit. Edge 7 carries a bit whose value has no effect.
- R2: On a write, edges 8 to 15 carry the data byte, least significant bit first. The write takes effect after edge 15.
- R3: On a read, SDO stays disabled during rising edges 6, 7 and 8. Data bit 0 appears on the falling edge after rising edge 8, and the following bits change on later falling edges, least significant bit first, so the controller samples bit k on rising edge 9+k. The output enable drops on the falling edge after rising edge 16, or when chip select deasserts.
- R4: Channel c (0..2) has a control register at address 6 + 8*c. It reads back as {2'b00, bits[5:0]}. Its bits drive `ch_cfg[6*c+5 : 6*c]`, and bit 2 of that slice is the jitter-attenuator enable.
- R5: Channel c has a read-only status register at address 7 + 8*c, which reads {7'b0, fifo_lim[c]}. Writes to it change nothing.
- R6: A read from any other address returns 0x00, and a write to any other address changes no register.
- R7: A frame whose must-be-zero bit is 1 changes no register, and a read of such a frame returns 0x00.
- R8: If chip select deasserts before rising edge 15 of a write, no register changes.
- R9: With `host_mode` low, the serial port has no effect: writes are ignored and SDO is never enabled. Bit 2 of each channel's `ch_cfg` slice then follows `ja_en_pin[c]`, while the other bits keep their register values.
- R10: After reset all control registers are zero, `ch_cfg` is zero and SDO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_mode | input | 1 | 1 = serial register control, 0 = pin control |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for sdo; low means high impedance |
| ja_en_pin | input | 3 | Per-channel jitter-attenuator enable used in pin mode |
| fifo_lim | input | 3 | Per-channel FIFO-limit status |
| ch_cfg | output | 18 | Six configuration bits per channel |

## Verification
The bench checks the idle gap before read data. A design that miscounts the gap drives SDO one edge early or late, so every readback arrives shifted by one bit position. Every one of the 32 addresses is read and written, which exposes decoders that alias the status addresses onto the control registers or that let writes reach unmapped space. Writes are aborted after each possible number of data bits, and a design that commits early leaves a register partly written. Frames with the must-be-zero bit set and traffic in pin mode must leave the registers untouched and SDO disabled, while pin mode must route the enable pins onto the configuration outputs.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int CFG_W  = 6;
  localparam int JA_BIT = 2;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/scr_frame.sv
module scr_frame #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_ok,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int ZERO_POS   = ADDR_W + 1;
  localparam int DATA_FIRST = ADDR_W + 3;
  localparam int CNT_END    = DATA_FIRST + DATA_W + 1;
  localparam int CNT_W      = $clog2(CNT_END + 1);

  logic              sclk_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              rw_q, rw_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              zbit_q, zbit_n;
  logic [DATA_W-1:0] wsh_q, wsh_n;
  logic [DATA_W-1:0] rsh_q, rsh_n;
  logic              wr_q, wr_n;
  logic              oe_q, oe_n;
  logic              rise, fall, active;

  assign rise   = sclk_s & ~sclk_d_q;
  assign fall   = ~sclk_s & sclk_d_q;
  assign active = host_mode & ~cs_s;

  always_comb begin
    cnt_n  = cnt_q;
    rw_n   = rw_q;
    addr_n = addr_q;
    zbit_n = zbit_q;
    wsh_n  = wsh_q;
    rsh_n  = rsh_q;
    oe_n   = oe_q;
    wr_n   = 1'b0;
    if (!active) begin
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (rise) begin
      if (cnt_q == '0) rw_n = sdi_s;
      for (int i = 0; i < ADDR_W; i++)
        if (cnt_q == CNT_W'(i + 1)) addr_n[i] = sdi_s;
      if (cnt_q == CNT_W'(ZERO_POS)) zbit_n = sdi_s;
      for (int i = 0; i < DATA_W; i++)
        if (cnt_q == CNT_W'(DATA_FIRST + i)) wsh_n[i] = sdi_s;
      if (cnt_q == CNT_W'(DATA_FIRST + DATA_W - 1) && !rw_q && !zbit_q)
        wr_n = 1'b1;
      if (cnt_q != CNT_W'(CNT_END)) cnt_n = cnt_q + 1'b1;
    end else if (fall && rw_q) begin
      if (cnt_q == CNT_W'(DATA_FIRST + 1)) begin
        rsh_n = rd_data;
        oe_n  = 1'b1;
      end else if (cnt_q > CNT_W'(DATA_FIRST + 1) && cnt_q <= CNT_W'(DATA_FIRST + DATA_W)) begin
        rsh_n = rsh_q >> 1;
      end else if (cnt_q == CNT_W'(CNT_END)) begin
        oe_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      zbit_q   <= 1'b0;
      wsh_q    <= '0;
      rsh_q    <= '0;
      wr_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      rw_q     <= rw_n;
      addr_q   <= addr_n;
      zbit_q   <= zbit_n;
      wsh_q    <= wsh_n;
      rsh_q    <= rsh_n;
      wr_q     <= wr_n;
      oe_q     <= oe_n;
    end
  end

  assign wr_stb  = wr_q;
  assign addr    = addr_q;
  assign addr_ok = ~zbit_q;
  assign wr_data = wsh_q;
  assign sdo     = rsh_q[0];
  assign sdo_oe  = oe_q;
endmodule

// File: rtl/scr_regbank.sv
module scr_regbank
  import scr_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 6,
  parameter int STRIDE    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_mode,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               addr_ok,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NCH-1:0]     ja_en_pin,
  input  logic [NCH-1:0]     fifo_lim,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NCH*CFG_W-1:0] ctrl_flat,
  output logic [NCH*CFG_W-1:0] ch_cfg
);
  logic [DATA_W-1:0] rd_part [NCH];
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(BASE_ADDR + c * STRIDE);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(BASE_ADDR + c * STRIDE + 1);

    logic [CFG_W-1:0] reg_q, reg_n;
    logic             wr_hit;

    assign wr_hit = wr_stb & addr_ok & (addr == CTRL_A);

    always_comb begin
      reg_n = reg_q;
      if (wr_hit) reg_n = wr_data[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= reg_n;
    end

    always_comb begin
      rd_part[c] = '0;
      if (addr_ok && addr == CTRL_A) rd_part[c] = DATA_W'(reg_q);
      if (addr_ok && addr == STAT_A) rd_part[c] = DATA_W'(fifo_lim[c]);
    end

    always_comb begin
      ch_cfg[c*CFG_W +: CFG_W] = reg_q;
      if (!host_mode) ch_cfg[c*CFG_W + JA_BIT] = ja_en_pin[c];
    end

    assign ctrl_flat[c*CFG_W +: CFG_W] = reg_q;
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) rd_data = rd_data | rd_part[c];
  end
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import scr_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int BASE_ADDR   = 6,
  parameter int STRIDE      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_mode,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  input  logic [NCH-1:0]       ja_en_pin,
  input  logic [NCH-1:0]       fifo_lim,
  output logic [NCH*CFG_W-1:0] ch_cfg
);
  logic [1:0]              rst_sh_q;
  logic                    rst_q;
  logic                    cs_s, sclk_s, sdi_s;
  logic                    wr_stb, addr_ok;
  logic [ADDR_W-1:0]       addr;
  logic [DATA_W-1:0]       wr_data, rd_data;
  logic [NCH*CFG_W-1:0]    ctrl_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_q = rst_sh_q[1];

  scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_q), .d(cs_n), .q(cs_s));
  scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_q), .d(sclk), .q(sclk_s));
  scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_q), .d(sdi), .q(sdi_s));

  scr_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_q), .host_mode(host_mode), .cs_s(cs_s),
    .sclk_s(sclk_s), .sdi_s(sdi_s), .rd_data(rd_data), .wr_stb(wr_stb),
    .addr(addr), .addr_ok(addr_ok), .wr_data(wr_data), .sdo(sdo),
    .sdo_oe(sdo_oe));

  scr_regbank #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)) u_regs (
    .clk(clk), .rst_n(rst_q), .host_mode(host_mode), .wr_stb(wr_stb),
    .addr(addr), .addr_ok(addr_ok), .wr_data(wr_data),
    .ja_en_pin(ja_en_pin), .fifo_lim(fifo_lim), .rd_data(rd_data),
    .ctrl_flat(ctrl_flat), .ch_cfg(ch_cfg));
endmodule

// File: rtl/serial_cfg_regs_chk.sv
module serial_cfg_regs_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_mode,
  input logic         cs_s,
  input logic         sdo_oe,
  input logic         wr_stb,
  input logic [W-1:0] ctrl_flat
);
  assert_pin_mode_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!host_mode) |-> !sdo_oe);

  assert_deselect_drops_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(ctrl_flat));

  assert_write_inside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(!cs_s && host_mode));

  assert_one_write_per_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

bind serial_cfg_regs serial_cfg_regs_chk #(.W(NCH*scr_pkg::CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .host_mode(host_mode), .cs_s(cs_s),
  .sdo_oe(sdo_oe), .wr_stb(wr_stb), .ctrl_flat(ctrl_flat));

// File: tb/tb_serial_cfg_regs.sv
module tb_serial_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic [2:0]  ja_en_pin = 3'b000;
  logic [2:0]  fifo_lim = 3'b000;
  logic [17:0] ch_cfg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [5:0] mdl [3];

  serial_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .ja_en_pin(ja_en_pin), .fifo_lim(fifo_lim), .ch_cfg(ch_cfg));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [4:0] a, input logic z);
    if (z) return 8'h00;
    for (int c = 0; c < 3; c++) begin
      if (a == 5'(6 + 8*c)) return {2'b00, mdl[c]};
      if (a == 5'(7 + 8*c)) return {7'b0, fifo_lim[c]};
    end
    return 8'h00;
  endfunction

  function automatic logic [17:0] exp_cfg();
    logic [17:0] v;
    for (int c = 0; c < 3; c++) begin
      v[c*6 +: 6] = mdl[c];
      if (!host_mode) v[c*6 + 2] = ja_en_pin[c];
    end
    return v;
  endfunction

  task automatic frame(input logic rw, input logic [4:0] a, input logic z, input logic dc,
                       input logic [7:0] wd, input int stop_at,
                       output logic [7:0] rd, output logic gap_ok, output logic oe_ok,
                       output logic oe_any);
    int nrise;
    nrise = rw ? 17 : 16;
    rd = 8'h00; gap_ok = 1'b1; oe_ok = 1'b1; oe_any = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int e = 0; e < nrise; e++) begin
      if (e == stop_at) break;
      if (e == 0)       sdi = rw;
      else if (e <= 5)  sdi = a[e-1];
      else if (e == 6)  sdi = z;
      else if (e == 7)  sdi = dc;
      else if (e <= 15) sdi = wd[e-8];
      else              sdi = 1'b0;
      repeat (HP) @(negedge clk);
      if (sdo_oe) oe_any = 1'b1;
      if (rw) begin
        if (e <= 8 && sdo_oe) gap_ok = 1'b0;
        if (e >= 9) begin
          if (!sdo_oe) oe_ok = 1'b0;
          rd[e-9] = sdo;
        end
      end
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    if (rw && sdo_oe) oe_ok = 1'b0;
    if (sdo_oe) oe_any = 1'b1;
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] wd);
    logic [7:0] r; logic g, o, y;
    frame(1'b0, a, 1'b0, wd[3], wd, 99, r, g, o, y);
  endtask

  task automatic do_read_chk(input string req, input logic [4:0] a);
    logic [7:0] r; logic g, o, y;
    frame(1'b1, a, 1'b0, a[0], 8'h00, 99, r, g, o, y);
    chk(req, {24'h0, r}, {24'h0, exp_rd(a, 1'b0)});
    chk("R3 idle gap", {31'h0, g}, 32'h1);
    chk("R3 enable window", {31'h0, o}, 32'h1);
  endtask

  initial begin
    for (int c = 0; c < 3; c++) mdl[c] = 6'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: reset state
    chk("R10 ch_cfg after reset", {14'h0, ch_cfg}, 32'h0);
    chk("R10 sdo_oe after reset", {31'h0, sdo_oe}, 32'h0);
    for (int c = 0; c < 3; c++) do_read_chk("R10 ctrl reads zero", 5'(6 + 8*c));

    // R1 R2 R4: every 6-bit value through the three channels, junk in upper bits and don't-care bit
    for (int v = 0; v < 64; v++) begin
      int c;
      logic [7:0] wd;
      c = v % 3;
      wd = {2'(v * 3), 6'(v)};
      do_write(5'(6 + 8*c), wd);
      mdl[c] = wd[5:0];
      chk("R4 ch_cfg after write", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
      do_read_chk("R2 R4 readback", 5'(6 + 8*c));
    end

    // R5 R6: full address sweep of reads with two status patterns
    fifo_lim = 3'b101;
    for (int a = 0; a < 32; a++) do_read_chk("R5 R6 address sweep", 5'(a));
    fifo_lim = 3'b010;
    for (int c = 0; c < 3; c++) do_read_chk("R5 status read", 5'(7 + 8*c));

    // R5 R6: writes everywhere but the control addresses change nothing
    mdl[0] = 6'h15; mdl[1] = 6'h2A; mdl[2] = 6'h33;
    for (int c = 0; c < 3; c++) do_write(5'(6 + 8*c), {2'b00, mdl[c]});
    for (int a = 0; a < 32; a++) begin
      if (a != 6 && a != 14 && a != 22) begin
        do_write(5'(a), 8'hFF);
        chk("R5 R6 stray write", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
      end
    end

    // R7: must-be-zero bit set
    begin
      logic [7:0] r; logic g, o, y;
      frame(1'b0, 5'd14, 1'b1, 1'b0, 8'h00, 99, r, g, o, y);
      chk("R7 write with zero-bit set", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
      frame(1'b1, 5'd14, 1'b1, 1'b0, 8'h00, 99, r, g, o, y);
      chk("R7 read with zero-bit set", {24'h0, r}, 32'h0);
    end

    // R8: aborted writes after each count of rising edges
    for (int s = 1; s <= 15; s++) begin
      logic [7:0] r; logic g, o, y;
      frame(1'b0, 5'd22, 1'b0, 1'b0, ~{2'b00, mdl[2]}, s, r, g, o, y);
      chk("R8 aborted write", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
    end
    do_read_chk("R8 readback after aborts", 5'd22);

    // R9: pin mode
    host_mode = 1'b0;
    for (int p = 0; p < 8; p++) begin
      ja_en_pin = 3'(p);
      repeat (2) @(negedge clk);
      chk("R9 pin-driven enable", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
    end
    begin
      logic [7:0] r; logic g, o, y;
      frame(1'b0, 5'd6, 1'b0, 1'b0, 8'h3F, 99, r, g, o, y);
      chk("R9 write ignored", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
      frame(1'b1, 5'd6, 1'b0, 1'b0, 8'h00, 99, r, g, o, y);
      chk("R9 sdo never enabled", {31'h0, y}, 32'h0);
    end
    host_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 registers kept", {14'h0, ch_cfg}, {14'h0, exp_cfg()});
    do_read_chk("R9 readback after pin mode", 5'd6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule